// File: doc/BRIEF.md
# Eight-Bit Handheld CPU Arithmetic and Logic Unit

This block is the arithmetic and logic datapath of a compact 8-bit CPU core. It takes a four-bit operation code, two 8-bit operands and an incoming carry. It returns an 8-bit result in the same cycle. It also keeps a four-flag register: zero, subtract, half-carry and carry. The flag register is written on a clock edge only when the flag-write enable is high. The core's decoder picks the operation and feeds the carry input back from the stored carry flag.

The operations cover:
- addition and subtraction, each with or without carry;
- the three bitwise logic operations;
- a compare;
- 8-bit rotates and 9-bit rotates through carry;
- logical and arithmetic shifts;
- a nibble swap.

Subtraction uses a borrow-style carry: carry set means a borrow occurred. No sign flag exists. To sign-extend, software rotates bit 7 into carry, then subtracts the accumulator from itself with borrow.

Operation codes (`op_i`): 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP, 8 RLC, 9 RRC, 10 RL, 11 RR, 12 SLA, 13 SRA, 14 SWAP, 15 SRL. Operand B is used only by codes 0 to 7. The carry input is used only by ADC, SBC, RL and RR.

Top module: `cpu8_alu`

## Requirements
- R1: ADD gives (A+B) mod 256 and ADC gives (A+B+cin) mod 256. C is set when the true sum exceeds 255. H is set when the sum of the low nibbles, plus cin for ADC, exceeds 15.
- R2: SUB gives (A-B) mod 256 and SBC gives (A-B-cin) mod 256. C is set when the true difference is negative (borrow). H is set when the low-nibble difference is negative (borrow out of bit 4).
- R3: CP sets Z, N, H and C exactly as SUB would for the same operands, while result_o equals A.
- R4: AND, XOR and OR give the bitwise result. They clear C and N. H is 1 after AND and 0 after XOR and OR.
- R5: Z is set when the 8-bit value is zero (for CP, the value is the difference). N is set only after SUB, SBC and CP.
- R6: RLC gives {A[6:0],A[7]} with C=A[7]. RRC gives {A[0],A[7:1]} with C=A[0]. Both clear N and H.
- R7: RL gives {A[6:0],cin} with C=A[7]. RR gives {cin,A[7:1]} with C=A[0]. Both clear N and H.
- R8: SLA gives {A[6:0],0} with C=A[7]. SRL gives {0,A[7:1]} with C=A[0]. SRA gives {A[7],A[7:1]} with C=A[0]. All three clear N and H.
- R9: SWAP gives {A[3:0],A[7:4]} and clears N, H and C.
- R10: flags_o holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3:0 always read zero. After reset, flags_o is 8'h00.
- R11: flags_o takes the flags of the current operation on a rising clock edge when flag_we_i is 1. It is unchanged when flag_we_i is 0.
- R12: RLC of a value V, followed by SBC of its result with itself (cin taken from stored C), yields 8'hFF when V[7] is 1 and 8'h00 when V[7] is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| carry_i | input | 1 | Incoming carry |
| flag_we_i | input | 1 | Flag register write enable |
| result_o | output | 8 | Combinational result |
| flags_o | output | 8 | Registered flags {Z,N,H,C,4'b0} |

## Verification
The hardest cases to reach are the half-borrow and half-carry edges that occur only with an incoming carry: equal low nibbles with cin set, or low nibbles summing to exactly 15. Another is the two-step sign-extension chain, whose second step depends on the carry stored by the first. The stimulus sweeps every operation over every A value. For each, it uses a set of B values clustered on nibble and byte boundaries, with both carry levels. The flags of each vector are checked one cycle later, overlapped with the next vector. A separate sequence runs the rotate-then-subtract chain, feeding the registered carry back into carry_i.

// File: rtl/cpu8_alu_pkg.sv
package cpu8_alu_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;
  localparam int unsigned OPW = 4;
  localparam int unsigned FW = 8;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CP   = 4'd7,
    OP_RLC  = 4'd8,
    OP_RRC  = 4'd9,
    OP_RL   = 4'd10,
    OP_RR   = 4'd11,
    OP_SLA  = 4'd12,
    OP_SRA  = 4'd13,
    OP_SWAP = 4'd14,
    OP_SRL  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flag_t;
endpackage

// File: rtl/cpu8_alu_arith.sv
module cpu8_alu_arith
  import cpu8_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic           carry_i,
  output logic [DW-1:0]  res_o,
  output flag_t          flags_o
);
  logic          is_sub, is_cp, use_cin, cin;
  logic [DW:0]   wide;
  logic [NW:0]   half;
  logic [DW-1:0] raw;

  always_comb begin
    is_cp   = (op_i == OP_CP);
    is_sub  = (op_i == OP_SUB) || (op_i == OP_SBC) || is_cp;
    use_cin = (op_i == OP_ADC) || (op_i == OP_SBC);
    cin     = use_cin & carry_i;
    if (is_sub) begin
      wide = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cin};
      half = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, cin};
    end else begin
      wide = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
      half = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cin};
    end
    raw       = wide[DW-1:0];
    res_o     = is_cp ? a_i : raw;
    flags_o.z = (raw == '0);
    flags_o.n = is_sub;
    flags_o.h = half[NW];
    flags_o.c = wide[DW];
  end
endmodule

// File: rtl/cpu8_alu_logic.sv
module cpu8_alu_logic
  import cpu8_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  output logic [DW-1:0]  res_o,
  output flag_t          flags_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i | b_i;
    endcase
    flags_o.z = (res_o == '0);
    flags_o.n = 1'b0;
    flags_o.h = (op_i == OP_AND);
    flags_o.c = 1'b0;
  end
endmodule

// File: rtl/cpu8_alu_shift.sv
module cpu8_alu_shift
  import cpu8_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic           carry_i,
  output logic [DW-1:0]  res_o,
  output flag_t          flags_o
);
  logic msb, lsb;
  logic fill_lo, fill_hi;

  always_comb begin
    msb = a_i[DW-1];
    lsb = a_i[0];
    // bit shifted into the vacated end
    unique case (op_i)
      OP_RLC:  fill_lo = msb;
      OP_RL:   fill_lo = carry_i;
      default: fill_lo = 1'b0;
    endcase
    unique case (op_i)
      OP_RRC:  fill_hi = lsb;
      OP_RR:   fill_hi = carry_i;
      OP_SRA:  fill_hi = msb;
      default: fill_hi = 1'b0;
    endcase
    unique case (op_i)
      OP_RLC, OP_RL, OP_SLA: begin
        res_o     = {a_i[DW-2:0], fill_lo};
        flags_o.c = msb;
      end
      OP_SWAP: begin
        res_o     = {a_i[NW-1:0], a_i[DW-1:NW]};
        flags_o.c = 1'b0;
      end
      default: begin
        res_o     = {fill_hi, a_i[DW-1:1]};
        flags_o.c = lsb;
      end
    endcase
    flags_o.z = (res_o == '0);
    flags_o.n = 1'b0;
    flags_o.h = 1'b0;
  end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
  import cpu8_alu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            carry_i,
  input  logic            flag_we_i,
  output logic [DW-1:0]   result_o,
  output logic [FW-1:0]   flags_o
);
  logic [DW-1:0] ar_res, lg_res, sh_res;
  flag_t         ar_flg, lg_flg, sh_flg, nxt_flg, flg_q;
  logic          sel_shift, sel_logic;

  cpu8_alu_arith u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(carry_i),
    .res_o(ar_res), .flags_o(ar_flg)
  );

  cpu8_alu_logic u_logic (
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(lg_res), .flags_o(lg_flg)
  );

  cpu8_alu_shift u_shift (
    .op_i(op_i), .a_i(a_i), .carry_i(carry_i),
    .res_o(sh_res), .flags_o(sh_flg)
  );

  always_comb begin
    sel_shift = op_i[OPW-1];
    sel_logic = (op_i == OP_AND) || (op_i == OP_XOR) || (op_i == OP_OR);
    if (sel_shift) begin
      result_o = sh_res;
      nxt_flg  = sh_flg;
    end else if (sel_logic) begin
      result_o = lg_res;
      nxt_flg  = lg_flg;
    end else begin
      result_o = ar_res;
      nxt_flg  = ar_flg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flg_q <= '0;
    else if (flag_we_i) flg_q <= nxt_flg;
  end

  assign flags_o = {flg_q, {(FW-4){1'b0}}};

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  assert_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i != OP_CP) |=> (flags_o[7] == ($past(result_o) == 8'h00)));

  assert_sub_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flags_o[6] == (($past(op_i) == OP_SUB) || ($past(op_i) == OP_SBC)
                                  || ($past(op_i) == OP_CP))));

  assert_cp_keeps_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CP) |-> (result_o == a_i));

  assert_and_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_AND) |=> (flags_o[5] && !flags_o[4]));

  assert_sra_msb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SRA) |-> (result_o[7] == a_i[7]));

  assert_swap_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_SWAP) |=> (flags_o[6:4] == 3'b000));

  assert_low_nibble_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flags_o[3:0] == 4'h0));
endmodule

// File: tb/cpu8_alu_test.sv
module cpu8_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic       we = 1'b0;
  logic [7:0] result, flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpu8_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .carry_i(cin), .flag_we_i(we), .result_o(result), .flags_o(flags)
  );

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6: return "R4";
      7: return "R3";
      8, 9: return "R6";
      10, 11: return "R7";
      12, 13, 15: return "R8";
      default: return "R9";
    endcase
  endfunction

  // returns {result, flags byte}
  function automatic logic [15:0] model(int o, int x, int y, int c);
    int r, s, zf, nf, hf, cf;
    nf = 0; hf = 0; cf = 0; r = 0;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        s = x + y + c; r = s % 256; cf = (s > 255);
        hf = ((x % 16) + (y % 16) + c) > 15;
      end
      2, 3, 7: begin
        if (o != 3) c = 0;
        s = x - y - c; r = (s + 256) % 256; cf = (s < 0);
        hf = ((x % 16) - (y % 16) - c) < 0; nf = 1;
      end
      4: begin r = x & y; hf = 1; end
      5: r = x ^ y;
      6: r = x | y;
      8:  begin r = (x * 2) % 256 + x / 128; cf = x / 128; end
      9:  begin r = x / 2 + (x % 2) * 128; cf = x % 2; end
      10: begin r = (x * 2) % 256 + c; cf = x / 128; end
      11: begin r = x / 2 + c * 128; cf = x % 2; end
      12: begin r = (x * 2) % 256; cf = x / 128; end
      13: begin r = x / 2 + (x / 128) * 128; cf = x % 2; end
      14: r = (x % 16) * 16 + x / 16;
      default: begin r = x / 2; cf = x % 2; end
    endcase
    zf = (r == 0);
    if (o == 7) r = x;
    return {r[7:0], zf[0], nf[0], hf[0], cf[0], 4'h0};
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    automatic int bset[8] = '{0, 1, 15, 16, 127, 128, 240, 255};
    automatic logic [15:0] prev = '0;
    automatic int prev_op = 0;
    automatic bit have_prev = 0;
    automatic logic [7:0] hold_val;
    automatic logic [15:0] e;

    repeat (3) @(negedge clk);
    check("R10", "reset flags", flags, 8'h00);
    rst_n = 1'b1;

    // full sweep, flags checked one cycle after each vector
    we = 1'b1;
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 256; x++) begin
        for (int bi = 0; bi < 8; bi++) begin
          for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            if (have_prev) check(req_of(prev_op), "flags", flags, prev[7:0]);
            op = o[3:0]; a = x[7:0]; b = bset[bi][7:0]; cin = c[0];
            e = model(o, x, bset[bi], c);
            #1;
            check(req_of(o), "result", result, e[15:8]);
            prev = e; prev_op = o; have_prev = 1;
          end
        end
      end
    end
    @(negedge clk);
    check(req_of(prev_op), "flags", flags, prev[7:0]);

    // R5 zero from compare difference; R3 result kept as A
    op = 4'd7; a = 8'h3C; b = 8'h3C; cin = 1'b1;
    #1 check("R3", "cp result", result, 8'h3C);
    @(negedge clk);
    check("R5", "cp equal flags", flags, 8'hC0);

    // R11 hold with write enable low
    op = 4'd2; a = 8'h00; b = 8'h01; cin = 1'b0; we = 1'b1;
    @(negedge clk);
    hold_val = flags;
    check("R11", "written flags", hold_val, 8'h70);
    we = 1'b0;
    for (int k = 0; k < 16; k++) begin
      op = k[3:0]; a = 8'(k * 17); b = 8'(255 - k); cin = k[0];
      @(negedge clk);
      check("R11", "held flags", flags, hold_val);
    end
    we = 1'b1;

    // R12 sign extension: RLC then SBC A,A with cin from stored C
    for (int v = 0; v < 256; v += 5) begin
      logic [7:0] rot;
      op = 4'd8; a = v[7:0];
      #1 rot = result;
      @(negedge clk);
      op = 4'd3; a = rot; b = rot; cin = flags[4];
      #1 check("R12", "sign extend", result, v[7] ? 8'hFF : 8'h00);
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule